// File: doc/BRIEF.md
# Repeat-Count Dual-Memory Dot Product Engine

This block computes the signed dot product of two vectors. The vectors sit in two separate single-port memories: one holds coefficients and one holds samples. A single start command carries both read base addresses, a result address and an element count. After accepting the command, the engine clears its accumulator. It then issues one read to each memory in the same cycle, once per cycle, and advances both read pointers by one after every read. A hardware countdown stops the reads after exactly the requested number, so no per-element loop control is needed.

Both memories are synchronous, so read data returns one cycle after the address. The engine registers the product in the next cycle and adds it to the accumulator in the cycle after that. This gives one multiply-accumulate per cycle. Once the last product has been added, the accumulator value is written through a separate result write port in a single cycle, and `done` pulses in that same cycle. The accumulator has as many guard bits above the full product width as the count field has bits, so no count the command can express can overflow it.

The memory and result ports are plain synchronous memory ports, not streams. The memories must return data exactly one cycle after an enabled address and cannot stall the engine, so no back-pressure exists anywhere in the block. `start`, `busy` and `done` are plain level and pulse controls.

Top module: `dotmac_engine`

## Requirements
- R1: While reset is applied, and afterwards until a start is accepted, `busy`, `done`, `c_en`, `x_en` and `r_we` are all low.
- R2: A start sampled while `busy` is low is accepted. For a count N greater than zero, `c_en` is high for exactly N consecutive cycles, beginning in the cycle after the accepting clock edge.
- R3: In every read cycle, `c_en` and `x_en` are high together. On the k-th read (k from 0), `c_addr` equals the coefficient base plus k and `x_addr` equals the sample base plus k, both modulo 2^AW, so an address wraps from the top of memory to 0.
- R4: The value on `r_wdata` is the signed sum of the N products of coefficient times sample, sign-extended to ACC_W bits. It is presented with `r_we` high for one cycle at `r_addr` equal to the result address. For N > 0, that cycle is the (N+3)-th cycle after the accepting edge.
- R5: `done` is high for exactly one cycle per accepted command, and that is the cycle in which `r_we` is high.
- R6: `busy` is high from the cycle after the accepting edge through the write cycle, and it is low in the cycle after the write.
- R7: A start raised while `busy` is high, with any operand values, does not alter the reads, the result value or the result address of the job in progress.
- R8: A count of zero issues no memory reads. It writes zero to the result address, with `r_we` and `done` high, in the first cycle after the accepting edge.
- R9: With a count of up to 2^NW-1 and operands at the most negative value, the written sum is exact, with no wraparound.
- R10: A start held during the write cycle is ignored. The same start held in the following cycle is accepted as a new job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request, sampled at each rising edge |
| cmd_cbase | input | AW | Coefficient vector base address |
| cmd_xbase | input | AW | Sample vector base address |
| cmd_dst | input | AW | Result address |
| cmd_len | input | NW | Element count N |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| c_en | output | 1 | Coefficient memory read enable |
| c_addr | output | AW | Coefficient memory address |
| c_rdata | input | DW | Coefficient read data, one cycle after address |
| x_en | output | 1 | Sample memory read enable |
| x_addr | output | AW | Sample memory address |
| x_rdata | input | DW | Sample read data, one cycle after address |
| r_we | output | 1 | Result write strobe |
| r_addr | output | AW | Result write address |
| r_wdata | output | ACC_W | Result write data (signed) |

## Verification
Two functions can fall in the same cycle. The first is the write-back of a finished job. The second is the arrival of a new start, which `busy` still rejects in that cycle but accepts one cycle later. The bench raises `start` with new operands at the falling edge where it first sees `done`, then holds it for one more cycle. The model accepts the command only at the second edge, so it predicts a single new job built from the second cycle's operands. Any early acceptance would corrupt the result being written, or would start reads one cycle too soon, and the cycle-by-cycle comparison reports either error.

// File: rtl/dotmac_pkg.sv
package dotmac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2,
    ST_WRITE = 2'd3
  } dm_state_e;
endpackage

// File: rtl/dotmac_ptr.sv
module dotmac_ptr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          inc,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] ptr
);
  // Post-incrementing address register; wraps naturally modulo 2^AW.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= base;
    else if (inc)  ptr <= ptr + AW'(1);
  end
endmodule

// File: rtl/dotmac_ctrl.sv
module dotmac_ctrl
  import dotmac_pkg::*;
#(
  parameter int NW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] len,
  output logic          load,
  output logic          issue,
  output logic          rd_v,
  output logic          wr,
  output logic          busy
);
  dm_state_e     state, state_n;
  logic [NW-1:0] rem;

  assign load  = (state == ST_IDLE) && start;
  assign issue = (state == ST_ISSUE);
  assign wr    = (state == ST_WRITE);
  assign busy  = (state != ST_IDLE);

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:  if (start) state_n = (len == '0) ? ST_WRITE : ST_ISSUE;
      ST_ISSUE: if (rem == NW'(1)) state_n = ST_DRAIN;
      // last product lands in the accumulator on the edge leaving this cycle
      ST_DRAIN: if (!rd_v) state_n = ST_WRITE;
      ST_WRITE: state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      rem   <= '0;
      rd_v  <= 1'b0;
    end else begin
      state <= state_n;
      rd_v  <= issue;
      if (load)       rem <= len;
      else if (issue) rem <= rem - NW'(1);
    end
  end
endmodule

// File: rtl/dotmac_dp.sv
module dotmac_dp #(
  parameter int DW    = 8,
  parameter int ACC_W = 22
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    rd_v,
  input  logic [DW-1:0]           a,
  input  logic [DW-1:0]           b,
  output logic signed [ACC_W-1:0] acc
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod_q;
  logic                 pr_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      pr_v   <= 1'b0;
      acc    <= '0;
    end else begin
      pr_v <= rd_v;
      if (rd_v) prod_q <= $signed(a) * $signed(b);
      if (clear)     acc <= '0;
      else if (pr_v) acc <= acc + ACC_W'(prod_q);
    end
  end
endmodule

// File: rtl/dotmac_engine.sv
module dotmac_engine #(
  parameter int AW    = 6,
  parameter int DW    = 8,
  parameter int NW    = 6,
  parameter int ACC_W = 2 * DW + NW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    cmd_cbase,
  input  logic [AW-1:0]    cmd_xbase,
  input  logic [AW-1:0]    cmd_dst,
  input  logic [NW-1:0]    cmd_len,
  output logic             busy,
  output logic             done,
  output logic             c_en,
  output logic [AW-1:0]    c_addr,
  input  logic [DW-1:0]    c_rdata,
  output logic             x_en,
  output logic [AW-1:0]    x_addr,
  input  logic [DW-1:0]    x_rdata,
  output logic             r_we,
  output logic [AW-1:0]    r_addr,
  output logic [ACC_W-1:0] r_wdata
);
  localparam int NPTR = 2;

  logic load, issue, rd_v, wr;
  logic [AW-1:0] base_v [NPTR];
  logic [AW-1:0] ptr_v  [NPTR];
  logic signed [ACC_W-1:0] acc;

  assign base_v[0] = cmd_cbase;
  assign base_v[1] = cmd_xbase;

  dotmac_ctrl #(.NW(NW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .len(cmd_len),
    .load(load), .issue(issue), .rd_v(rd_v), .wr(wr), .busy(busy)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dotmac_ptr #(.AW(AW)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(load), .inc(issue),
      .base(base_v[g]), .ptr(ptr_v[g])
    );
  end

  dotmac_ptr #(.AW(AW)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(load), .inc(1'b0),
    .base(cmd_dst), .ptr(r_addr)
  );

  dotmac_dp #(.DW(DW), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .clear(load), .rd_v(rd_v),
    .a(c_rdata), .b(x_rdata), .acc(acc)
  );

  assign c_en    = issue;
  assign x_en    = issue;
  assign c_addr  = ptr_v[0];
  assign x_addr  = ptr_v[1];
  assign r_we    = wr;
  assign done    = wr;
  assign r_wdata = acc;
endmodule

// File: rtl/dotmac_engine_chk.sv
module dotmac_engine_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          c_en,
  input logic [AW-1:0] c_addr,
  input logic          x_en,
  input logic [AW-1:0] x_addr,
  input logic          r_we
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!c_en && !x_en && !r_we && !done));

  // R3
  dual_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_en == x_en);

  // R3
  c_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_en && $past(c_en)) |-> (c_addr == $past(c_addr) + AW'(1)));

  // R3
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_en && $past(x_en)) |-> (x_addr == $past(x_addr) + AW'(1)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !r_we) |=> busy);

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_we |=> !busy);
endmodule

bind dotmac_engine dotmac_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .c_en(c_en), .c_addr(c_addr), .x_en(x_en), .x_addr(x_addr), .r_we(r_we)
);

// File: tb/dotmac_engine_bench.sv
module dotmac_engine_bench;
  localparam int AW = 6, DW = 8, NW = 6, ACC_W = 2 * DW + NW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] cmd_cbase = '0, cmd_xbase = '0, cmd_dst = '0;
  logic [NW-1:0] cmd_len = '0;
  logic busy, done, c_en, x_en, r_we;
  logic [AW-1:0] c_addr, x_addr, r_addr;
  logic [DW-1:0] c_rdata = '0, x_rdata = '0;
  logic [ACC_W-1:0] r_wdata;

  logic signed [DW-1:0] cmem [DEPTH];
  logic signed [DW-1:0] xmem [DEPTH];

  int checks = 0, fails = 0;
  string tag_next = "R4";

  always #2.5 clk = ~clk;

  dotmac_engine #(.AW(AW), .DW(DW), .NW(NW)) u_dotmac_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_cbase(cmd_cbase),
    .cmd_xbase(cmd_xbase), .cmd_dst(cmd_dst), .cmd_len(cmd_len),
    .busy(busy), .done(done), .c_en(c_en), .c_addr(c_addr), .c_rdata(c_rdata),
    .x_en(x_en), .x_addr(x_addr), .x_rdata(x_rdata),
    .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata)
  );

  // synchronous-read memories
  always @(posedge clk) begin
    if (c_en) c_rdata <= cmem[c_addr];
    if (x_en) x_rdata <= xmem[x_addr];
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint dot(input int cb, input int xb, input int n);
    longint s = 0;
    for (int i = 0; i < n; i++)
      s += longint'(cmem[(cb + i) % DEPTH]) * longint'(xmem[(xb + i) % DEPTH]);
    return s;
  endfunction

  // behavioural reference model
  int     cyc = 0, m_t0 = 0, m_n = 0, m_last = 0, m_cb = 0, m_xb = 0, m_db = 0;
  bit     m_busy = 0;
  longint m_sum = 0;
  string  m_tag = "R4";

  always @(posedge clk) begin
    if (rst_n) begin
      if (m_busy && (cyc - m_t0) == m_last) m_busy <= 0;
      else if (!m_busy && start) begin
        m_busy <= 1;
        m_t0   <= cyc;
        m_n    <= int'(cmd_len);
        m_last <= (cmd_len == 0) ? 1 : int'(cmd_len) + 3;
        m_cb   <= int'(cmd_cbase);
        m_xb   <= int'(cmd_xbase);
        m_db   <= int'(cmd_dst);
        m_sum  <= dot(int'(cmd_cbase), int'(cmd_xbase), int'(cmd_len));
        m_tag  <= tag_next;
      end
    end
    cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      automatic int k = cyc - m_t0;
      automatic bit e_en = m_busy && k >= 1 && k <= m_n;
      automatic bit e_we = m_busy && k == m_last;
      check(busy == m_busy, "R6 busy", busy, m_busy);
      check(c_en == e_en, "R2 c_en", c_en, e_en);
      check(x_en == e_en, "R3 x_en", x_en, e_en);
      check(r_we == e_we, "R4 r_we", r_we, e_we);
      check(done == e_we, "R5 done", done, e_we);
      if (e_en) begin
        check(int'(c_addr) == (m_cb + k - 1) % DEPTH, "R3 c_addr", c_addr, (m_cb + k - 1) % DEPTH);
        check(int'(x_addr) == (m_xb + k - 1) % DEPTH, "R3 x_addr", x_addr, (m_xb + k - 1) % DEPTH);
      end
      if (e_we) begin
        check(longint'($signed(r_wdata)) == m_sum, m_tag, longint'($signed(r_wdata)), m_sum);
        check(int'(r_addr) == m_db, "R4 r_addr", r_addr, m_db);
      end
    end
  end

  task automatic go(input int cb, input int xb, input int db, input int n, input string tag);
    @(negedge clk);
    cmd_cbase = AW'(cb); cmd_xbase = AW'(xb); cmd_dst = AW'(db); cmd_len = NW'(n);
    tag_next = tag; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      cmem[i] = DW'((i * 37 + 11) % 256);
      xmem[i] = DW'((i * 91 + 5) % 256);
    end
    for (int i = 40; i < 60; i++) begin
      cmem[i] = -8'sd128;
      xmem[i] = -8'sd128;
    end
    repeat (3) @(negedge clk);
    // R1: quiet outputs under reset
    check(!busy && !done && !c_en && !x_en && !r_we, "R1 reset",
          {busy, done, c_en, x_en, r_we}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !c_en && !r_we, "R1 idle", {busy, c_en, r_we}, 0);

    go(0, 10, 5, 4, "R4 sum");
    go(60, 2, 7, 8, "R3 wrap sum");
    go(3, 9, 12, 0, "R8 zero len");
    go(40, 40, 9, 20, "R9 extreme sum");
    go(0, 32, 2, 63, "R9 max len");
    go(17, 21, 33, 1, "R2 single");

    // R7: second start raised mid-job must be ignored
    @(negedge clk);
    cmd_cbase = 6'd5; cmd_xbase = 6'd6; cmd_dst = 6'd20; cmd_len = 6'd6;
    tag_next = "R7 kept sum"; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    cmd_cbase = 6'd50; cmd_xbase = 6'd1; cmd_dst = 6'd63; cmd_len = 6'd2;
    tag_next = "R7 intruder"; start = 1'b1;
    repeat (3) @(negedge clk); start = 1'b0;
    while (m_busy) @(negedge clk);

    // R10: start in the write cycle ignored, accepted in the next
    @(negedge clk);
    cmd_cbase = 6'd8; cmd_xbase = 6'd30; cmd_dst = 6'd1; cmd_len = 6'd3;
    tag_next = "R4 first"; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    cmd_cbase = 6'd12; cmd_xbase = 6'd44; cmd_dst = 6'd4; cmd_len = 6'd5;
    tag_next = "R10 back to back"; start = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R10 idle gap", busy, 0);
    @(negedge clk); start = 1'b0;
    while (m_busy) @(negedge clk);
    go(1, 2, 3, 0, "R8 zero again");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule